// File: doc/BRIEF.md
# Index-Remapped ARX Round Sequencer

This block runs add-rotate-xor rounds over a small register file whose 64-bit registers each carry two 32-bit elements. Which elements take part in each operation is not wired into the datapath. It comes from three tables of 8-bit element numbers that are loaded before a run. In each of 32 element steps the block performs three operations, one per clock cycle: an add, then a xor, then a left rotate. Each operation selects its elements through its own table. The block then moves on to the next step. After 32 steps the pass is complete, and the whole pass repeats for a programmed number of outer iterations.

Element numbers count from a base register that is captured at start. The state array can therefore sit anywhere in the file. Load the column and diagonal quarter-round patterns into the tables with an outer count of ten, and the block computes the twenty-round core permutation of the ChaCha stream cipher in place. Other table contents give other add/xor/rotate schedules over the same hardware.

Top module: `arx_index_seq`

## Requirements
- R1: After reset, `busy` and `done` are both low.
- R2: A table word write with `tab_we` high and `busy` low stores `tab_data` as word `tab_word` of table `tab_sel`. The selector values are 0 for table T, 1 for table B and 2 for table X. Selector 3 writes nothing. Entry 8k+j of a table lies in bits [8j+7:8j] of word k.
- R3: Element n of the state is register `base+(n>>1)`, using bits [31:0] when n is even and bits [63:32] when n is odd. No register outside the addressed ones is changed.
- R4: In step i the block first sets element T[i] to T[i]+B[i] modulo 2^32. It then sets X[i] to X[i] xor T[i], using the new T[i]. Finally it rotates X[i] left. Each of these three operations takes one cycle.
- R5: The rotate amount in step i depends on i mod 4: 16, 12, 8 and 7 for remainders 0, 1, 2 and 3.
- R6: One pass is 32 steps. A run with outer count N holds `busy` high for exactly 96·N cycles, starting in the cycle after `start`.
- R7: `done` pulses high for one cycle, in the cycle after the last write, and `busy` is low at that point. With an outer count of 0, `done` pulses in the cycle after `start` and the state is not changed.
- R8: While `busy` is high, the block ignores table writes, register loads and `start`.
- R9: With the column/diagonal tables and an outer count of 10, the state equals ten ChaCha double rounds applied to the initial state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tab_we | input | 1 | Table word write strobe |
| tab_sel | input | 2 | Table select: 0 T, 1 B, 2 X |
| tab_word | input | 2 | Word within the table |
| tab_data | input | 64 | Eight packed 8-bit element numbers |
| ld_we | input | 1 | Register load strobe |
| ld_addr | input | AW (4) | Register to load |
| ld_data | input | 64 | Register load data |
| rd_addr | input | AW (4) | Read register select |
| rd_data | output | 64 | Register contents, combinational |
| base_reg | input | AW (4) | Base register of the state array, captured at start |
| outer_cnt | input | CW (8) | Number of 32-step passes |
| start | input | 1 | Start a run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Checking the final state against ChaCha shows that everything works together, but it cannot show that stimulus arriving mid-run is ignored unless that stimulus really lands while the sequencer is busy. The bench therefore counts busy cycles. On the 40th busy cycle it drives, all in the same cycle, a table write of all ones, a load of the first state register and a fresh `start`. It then requires both the double-round result and the 96·N busy length to come out unchanged. Random tables with a non-zero base and a prior write with selector 3 cover the index decode, the placement in halves and the rotate-amount cycle independently of the cipher pattern.

// File: rtl/arx_index_seq.sv
module arx_index_seq #(
  parameter int REGS = 16,
  parameter int CW   = 8,
  parameter int AW   = $clog2(REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tab_we,
  input  logic [1:0]    tab_sel,
  input  logic [1:0]    tab_word,
  input  logic [63:0]   tab_data,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [63:0]   ld_data,
  input  logic [AW-1:0] rd_addr,
  output logic [63:0]   rd_data,
  input  logic [AW-1:0] base_reg,
  input  logic [CW-1:0] outer_cnt,
  input  logic          start,
  output logic          busy,
  output logic          done
);
  localparam int STEPS = 32;
  localparam int SW    = $clog2(STEPS);
  localparam int TBITS = 3 * STEPS * 8;
  localparam logic [1:0] PH_ADD = 2'd0, PH_XOR = 2'd1, PH_ROT = 2'd2;

  logic [63:0]    rf [REGS];
  logic [TBITS-1:0] tbl_q;
  logic [1:0]     phase;
  logic [SW-1:0]  step;
  logic [CW-1:0]  outer;
  logic [AW-1:0]  base_q;

  logic [7:0]  t_idx, b_idx, x_idx, dst_idx, src_idx;
  logic [AW-1:0] dst_reg, src_reg;
  logic [31:0] dst_val, src_val, rot_val, result;
  logic [4:0]  shamt;
  logic        last_step;

  assign t_idx = tbl_q[8*(int'(step))           +: 8];
  assign b_idx = tbl_q[8*(int'(step) + STEPS)   +: 8];
  assign x_idx = tbl_q[8*(int'(step) + 2*STEPS) +: 8];

  assign dst_idx = (phase == PH_ADD) ? t_idx : x_idx;
  assign src_idx = (phase == PH_ADD) ? b_idx : t_idx;
  assign dst_reg = base_q + AW'(dst_idx[7:1]);
  assign src_reg = base_q + AW'(src_idx[7:1]);
  assign dst_val = dst_idx[0] ? rf[dst_reg][63:32] : rf[dst_reg][31:0];
  assign src_val = src_idx[0] ? rf[src_reg][63:32] : rf[src_reg][31:0];

  always_comb begin
    case (step[1:0])
      2'd0:    shamt = 5'd16;
      2'd1:    shamt = 5'd12;
      2'd2:    shamt = 5'd8;
      default: shamt = 5'd7;
    endcase
  end

  assign rot_val = (dst_val << shamt) | (dst_val >> (6'd32 - {1'b0, shamt}));

  always_comb begin
    case (phase)
      PH_ADD:  result = dst_val + src_val;
      PH_XOR:  result = dst_val ^ src_val;
      default: result = rot_val;
    endcase
  end

  assign last_step = (step == SW'(STEPS - 1));
  assign rd_data   = rf[rd_addr];

  always_ff @(posedge clk) begin
    if (busy) begin
      if (dst_idx[0]) rf[dst_reg][63:32] <= result;
      else            rf[dst_reg][31:0]  <= result;
    end else if (ld_we) begin
      rf[ld_addr] <= ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      tbl_q <= '0;
    else if (!busy && tab_we && tab_sel != 2'd3)
      tbl_q[64*(4*int'(tab_sel) + int'(tab_word)) +: 64] <= tab_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      phase  <= PH_ADD;
      step   <= '0;
      outer  <= '0;
      base_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          base_q <= base_reg;
          if (outer_cnt == '0) begin
            done <= 1'b1;
          end else begin
            busy  <= 1'b1;
            phase <= PH_ADD;
            step  <= '0;
            outer <= outer_cnt;
          end
        end
      end else begin
        case (phase)
          PH_ADD: phase <= PH_XOR;
          PH_XOR: phase <= PH_ROT;
          default: begin
            phase <= PH_ADD;
            step  <= step + 1'b1;
            if (last_step) begin
              outer <= outer - 1'b1;
              if (outer == CW'(1)) begin
                busy <= 1'b0;
                done <= 1'b1;
              end
            end
          end
        endcase
      end
    end
  end
endmodule

module arx_index_seq_chk #(
  parameter int TBITS = 768,
  parameter int SW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic [1:0]       phase,
  input logic [SW-1:0]    step,
  input logic [TBITS-1:0] tbl_q
);
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r7_fall_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r4_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> phase != 2'd3);

  a_r4_add_then_xor: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && $past(phase) == 2'd0 |-> phase == 2'd1);

  a_r6_step_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && $past(phase) != 2'd2 |-> $stable(step));

  a_r8_tables_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(tbl_q));
endmodule

bind arx_index_seq arx_index_seq_chk #(.TBITS(TBITS), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .phase(phase), .step(step), .tbl_q(tbl_q)
);

// File: tb/arx_index_seq_tb.sv
`timescale 1ns/1ps
module arx_index_seq_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tab_we = 1'b0, ld_we = 1'b0, start = 1'b0;
  logic [1:0]  tab_sel = '0, tab_word = '0;
  logic [63:0] tab_data = '0, ld_data = '0;
  logic [3:0]  ld_addr = '0, rd_addr = '0, base_reg = '0;
  logic [7:0]  outer_cnt = '0;
  logic [63:0] rd_data;
  logic        busy, done;

  int checks = 0, fails = 0;
  int q_addr[$];
  logic [63:0] q_exp[$];
  string q_tag[$];
  logic [7:0]  tt [3][32];
  logic [31:0] ms [16];
  logic [31:0] init_st [16];

  always #2.5 clk = ~clk;

  arx_index_seq u_dut (.*);

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      while (q_addr.size() > 0) begin
        rd_addr = q_addr[0][3:0];
        #0.1;
        chk(rd_data === q_exp[0], q_tag[0], $sformatf("reg%0d", q_addr[0]), rd_data, q_exp[0]);
        void'(q_addr.pop_front());
        void'(q_exp.pop_front());
        void'(q_tag.pop_front());
      end
    end
  end

  function automatic logic [31:0] rotl(logic [31:0] v, int s);
    return (v << s) | (v >> (32 - s));
  endfunction

  task automatic qr(int a, int b, int c, int d);
    ms[a] += ms[b]; ms[d] = rotl(ms[d] ^ ms[a], 16);
    ms[c] += ms[d]; ms[b] = rotl(ms[b] ^ ms[c], 12);
    ms[a] += ms[b]; ms[d] = rotl(ms[d] ^ ms[a], 8);
    ms[c] += ms[d]; ms[b] = rotl(ms[b] ^ ms[c], 7);
  endtask

  task automatic chacha(int n);
    for (int o = 0; o < n; o++) begin
      for (int q = 0; q < 4; q++) qr(q, 4 + q, 8 + q, 12 + q);
      for (int q = 0; q < 4; q++) qr(q, 4 + (q + 1) % 4, 8 + (q + 2) % 4, 12 + (q + 3) % 4);
    end
  endtask

  task automatic model_seq(int n);
    int sh[4] = '{16, 12, 8, 7};
    for (int o = 0; o < n; o++)
      for (int i = 0; i < 32; i++) begin
        ms[tt[0][i]] += ms[tt[1][i]];
        ms[tt[2][i]] ^= ms[tt[0][i]];
        ms[tt[2][i]] = rotl(ms[tt[2][i]], sh[i % 4]);
      end
  endtask

  task automatic chacha_tables();
    int a, b, c, d, k;
    for (int g = 0; g < 8; g++) begin
      k = g % 4;
      a = k; b = 4 + (g < 4 ? k : (k + 1) % 4);
      c = 8 + (g < 4 ? k : (k + 2) % 4); d = 12 + (g < 4 ? k : (k + 3) % 4);
      for (int j = 0; j < 4; j++) begin
        tt[0][4*g+j] = 8'((j % 2) ? c : a);
        tt[1][4*g+j] = 8'((j % 2) ? d : b);
        tt[2][4*g+j] = 8'((j % 2) ? b : d);
      end
    end
  endtask

  task automatic write_tables();
    for (int s = 0; s < 3; s++)
      for (int w = 0; w < 4; w++) begin
        tab_sel = 2'(s); tab_word = 2'(w); tab_we = 1'b1;
        for (int j = 0; j < 8; j++) tab_data[8*j +: 8] = tt[s][8*w + j];
        @(negedge clk);
      end
    tab_we = 1'b0;
  endtask

  task automatic load_state(int base);
    for (int k = 0; k < 8; k++) begin
      ld_addr = 4'(base + k); ld_data = {ms[2*k+1], ms[2*k]}; ld_we = 1'b1;
      @(negedge clk);
    end
    ld_we = 1'b0;
  endtask

  task automatic expect_state(int base, string tag);
    for (int k = 0; k < 8; k++) begin
      q_addr.push_back(base + k);
      q_exp.push_back({ms[2*k+1], ms[2*k]});
      q_tag.push_back(tag);
    end
  endtask

  task automatic run(int base, int n, bit disturb, string tag);
    int bcnt = 0;
    base_reg = 4'(base); outer_cnt = 8'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    forever begin
      if (busy) bcnt++;
      if (done) break;
      if (disturb && bcnt == 40) begin
        tab_we = 1'b1; tab_sel = 2'd0; tab_word = 2'd0; tab_data = '1;
        ld_we = 1'b1; ld_addr = 4'(base); ld_data = '1;
        start = 1'b1; outer_cnt = 8'd3;
      end else begin
        tab_we = 1'b0; ld_we = 1'b0; start = 1'b0;
      end
      @(negedge clk);
    end
    @(negedge clk);
    chk(bcnt == 96 * n, tag, "busy cycles", 64'(bcnt), 64'(96 * n));
    chk(q_addr.size() == 0, tag, "results drained", 64'(q_addr.size()), 64'd0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1", "busy after reset", 64'(busy), 64'd0);
    chk(done === 1'b0, "R1", "done after reset", 64'(done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: bench quarter-round against a published vector
    ms[0] = 32'h11111111; ms[1] = 32'h01020304; ms[2] = 32'h9b8d6f43; ms[3] = 32'h01234567;
    qr(0, 1, 2, 3);
    chk({ms[0], ms[1], ms[2], ms[3]} == 128'hea2a92f4_cb1cf8ce_4581472e_5881c4bb,
        "R9", "model qr", {ms[0], ms[1]}, 64'hea2a92f4_cb1cf8ce);

    for (int i = 0; i < 16; i++) init_st[i] = (32'h9E3779B9 * 32'(i + 1)) ^ 32'h12345678;

    // R9 R4 R6: ten double rounds at base 0
    chacha_tables();
    write_tables();
    ms = init_st; load_state(0);
    chacha(10); expect_state(0, "R9");
    run(0, 10, 1'b0, "R6");

    // R3: base 8, lower registers keep a sentinel
    for (int i = 0; i < 16; i++) ms[i] = 32'hA5A5_0000 | 32'(i);
    load_state(0); expect_state(0, "R3");
    ms = init_st; load_state(8);
    chacha(1); expect_state(8, "R3");
    run(8, 1, 1'b0, "R3");

    // R7: zero outer count leaves state unchanged
    ms = init_st; load_state(0); expect_state(0, "R7");
    run(0, 0, 1'b0, "R7");

    // R8: writes, loads and start during a run are ignored
    ms = init_st; load_state(0);
    chacha(2); expect_state(0, "R8");
    run(0, 2, 1'b1, "R8");

    // R2 R4 R5: random tables, selector 3 write ignored, base 4
    for (int s = 0; s < 3; s++)
      for (int i = 0; i < 32; i++) tt[s][i] = 8'($urandom_range(0, 15));
    write_tables();
    tab_sel = 2'd3; tab_word = 2'd0; tab_data = '0; tab_we = 1'b1;
    @(negedge clk);
    tab_we = 1'b0;
    ms = init_st; load_state(4);
    model_seq(3); expect_state(4, "R2/R4/R5");
    run(4, 3, 1'b0, "R5");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule